// File: doc/BRIEF.md
# Quad-Channel PCM Time-Slot Port

This block connects four voice channels to one serial PCM highway. All channels share a single transmit line and a single receive line. Each channel also has its own transmit and receive frame-sync input, and those syncs decide where in the frame that channel's slot falls. A slot always carries one 8-bit companded sample, most significant bit first. The transmit side sends the sample of the channel whose sync arrived. While it drives the line it raises an output enable and pulls an active-low slot-control pin low. Each receive lane shifts in 8 bits from the shared line and hands the finished byte to the core.

A sync is recognised on its rising edge, sampled by the rising highway clock. Two sync formats are supported:
- **Long format.** The first bit appears on the edge that sees the sync rise.
- **Short format.** The sync is one clock wide, and the first bit appears one edge later.

Transmit bits change on rising clock edges. Receive bits are sampled on falling edges. A channel whose power-down input is high takes no part on the highway.

Received bytes leave on a valid strobe that lasts one cycle. There is no ready input. The highway cannot stall, so the consumer must take each byte in the cycle its strobe is high. The transmit byte of a channel is read from the parallel input on the edge that drives its first bit, and it must be stable at that edge.

Top module: `pcm_hwy_port`

## Requirements
- R1: In long format, when a channel's transmit sync is seen rising at edge k, that channel's byte goes out on `dx` MSB first. Bit 7 is visible after edge k and bit 0 after edge k+7, with `dx_oe` high throughout.
- R2: In short format, a transmit sync sampled high at edge k gives no output after edge k. Bit 7 appears after edge k+1 and bit 0 after edge k+8.
- R3: In long format, a receive sync rising at edge k means bit 7 is on `dr` during the cycle after edge k and bit 0 during the cycle after edge k+7. The byte appears on that channel's lane of `rx_data` after edge k+8, and its `rx_valid` bit is high for that cycle.
- R4: In short format, a receive sync at edge k means bit 7 is on `dr` during the cycle after edge k+1. The byte and its strobe appear after edge k+9.
- R5: When no slot is active, `dx_oe` is low and `dx` is 0.
- R6: `tsc_n` is low exactly in the cycles where `dx_oe` is high.
- R7: Every slot is exactly 8 bits long. A sync for another channel that arrives as the last bit goes out starts a new slot with no gap, and the line is released after that slot's eighth bit.
- R8: If several enabled channels' transmit syncs rise at the same edge, the lowest-numbered channel is sent. `tx_collision` is high for the one cycle after that edge.
- R9: A transmit sync of a powered-down channel is ignored. If the transmitting channel is powered down in the middle of its slot, `dx_oe` falls at the next edge.
- R10: A powered-down channel captures nothing and raises no `rx_valid`.
- R11: A sync held high for several cycles starts only one slot.
- R12: Each `rx_valid` bit is a one-cycle strobe, and `rx_data` for a lane holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_long | input | 1 | 1 = long sync format, 0 = short |
| fsx | input | 4 | Per-channel transmit frame sync |
| fsr | input | 4 | Per-channel receive frame sync |
| pdn | input | 4 | Per-channel power-down, high = off |
| tx_data | input | 32 | Transmit bytes, channel n in bits [8n+7:8n] |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit line drive enable |
| tsc_n | output | 1 | Active-low slot-control, low while driving |
| tx_collision | output | 1 | One-cycle pulse on simultaneous transmit syncs |
| rx_data | output | 32 | Received bytes, channel n in bits [8n+7:8n] |
| rx_valid | output | 4 | Per-channel one-cycle receive strobe |

## Verification
Some properties are checked by assertions on every cycle:
- the line is quiet whenever the drive enable is low;
- `tsc_n` tracks the drive enable;
- no slot runs longer than eight bits after its load;
- a power-down in the middle of a slot ends the drive at the next edge;
- receive strobes last one cycle, are never raised for a powered-down lane, and leave the byte stable between them.

Other behaviour only the directed scenarios can show:
- the bit order and the exact starting edge in each sync format;
- the choice of winner on a collision;
- seamless back-to-back slots;
- ignored syncs of powered-down channels;
- single-slot behaviour under a long-held sync.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;
  typedef enum logic {
    FRAME_SHORT = 1'b0,
    FRAME_LONG  = 1'b1
  } frame_fmt_e;

  localparam int unsigned SLOT_BITS = 8;
  localparam int unsigned NUM_CH    = 4;
endpackage

// File: rtl/pcm_hwy_tx.sv
module pcm_hwy_tx #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned SLOT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  long_mode,
  input  logic [NCH-1:0]        fsx,
  input  logic [NCH-1:0]        pdn,
  input  logic [NCH*SLOT_W-1:0] tx_data,
  output logic                  dx,
  output logic                  dx_oe,
  output logic                  tsc_n,
  output logic                  collision
);
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned CNT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

  logic [NCH-1:0]    fsx_prev;
  logic [NCH-1:0]    rises;
  logic [CH_W-1:0]   win_ch;
  logic              found;
  logic              multi;
  logic              pend;
  logic [CH_W-1:0]   pend_ch;
  logic              req;
  logic [CH_W-1:0]   req_ch;
  logic [SLOT_W-1:0] sel_byte;
  logic              slot_free;
  logic              load;
  logic [CH_W-1:0]   cur_ch;
  logic [SLOT_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  // Rising sync edges of enabled channels only
  assign rises = fsx & ~fsx_prev & ~pdn;
  assign multi = (rises & (rises - 1'b1)) != '0;

  // Fixed priority: lowest channel index wins
  always_comb begin
    win_ch = '0;
    found  = 1'b0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (rises[i] && !found) begin
        win_ch = CH_W'(i);
        found  = 1'b1;
      end
    end
  end

  // Long format loads on the sync edge, short format one edge later
  assign req       = long_mode ? found  : pend;
  assign req_ch    = long_mode ? win_ch : pend_ch;
  assign sel_byte  = tx_data[int'(req_ch)*SLOT_W +: SLOT_W];
  assign slot_free = !dx_oe || (cnt == LAST);
  assign load      = req && slot_free && !pdn[req_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsx_prev  <= '0;
      collision <= 1'b0;
      pend      <= 1'b0;
      pend_ch   <= '0;
      cur_ch    <= '0;
      shreg     <= '0;
      cnt       <= '0;
      dx        <= 1'b0;
      dx_oe     <= 1'b0;
      tsc_n     <= 1'b1;
    end else begin
      fsx_prev  <= fsx;
      collision <= multi;
      pend      <= !long_mode && found;
      pend_ch   <= win_ch;
      if (load) begin
        cur_ch <= req_ch;
        dx     <= sel_byte[SLOT_W-1];
        shreg  <= sel_byte << 1;
        cnt    <= '0;
        dx_oe  <= 1'b1;
        tsc_n  <= 1'b0;
      end else if (dx_oe && ((cnt == LAST) || pdn[cur_ch])) begin
        dx    <= 1'b0;
        cnt   <= '0;
        dx_oe <= 1'b0;
        tsc_n <= 1'b1;
      end else if (dx_oe) begin
        dx    <= shreg[SLOT_W-1];
        shreg <= shreg << 1;
        cnt   <= cnt + 1'b1;
      end
    end
  end

  // Checker-side slot length counter
  logic [CNT_W:0] since_load;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     since_load <= '0;
    else if (load)  since_load <= '0;
    else if (dx_oe) since_load <= since_load + 1'b1;
  end

  a_r5_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_oe |-> !dx);
  a_r6_tsc_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    tsc_n == !dx_oe);
  a_r7_slot_len: assert property (@(posedge clk) disable iff (!rst_n)
    dx_oe |-> (since_load < (CNT_W+1)'(SLOT_W)));
  a_r9_pdn_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe && pdn[cur_ch] && !load) |=> !dx_oe);
endmodule

// File: rtl/pcm_hwy_rx_lane.sv
module pcm_hwy_rx_lane #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode,
  input  logic              fsr,
  input  logic              pdn,
  input  logic              dr_bit,
  output logic [SLOT_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam int unsigned CNT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

  logic              fsr_prev;
  logic              rise;
  logic              pend;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] shreg;

  assign rise = fsr && !fsr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_prev <= 1'b0;
      pend     <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      fsr_prev <= fsr;
      rx_valid <= 1'b0;
      if (pdn) begin
        pend   <= 1'b0;
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        shreg <= {shreg[SLOT_W-2:0], dr_bit};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          active   <= 1'b0;
          cnt      <= '0;
          rx_byte  <= {shreg[SLOT_W-2:0], dr_bit};
          rx_valid <= 1'b1;
        end
      end else if (pend) begin
        pend   <= 1'b0;
        active <= 1'b1;
        cnt    <= '0;
      end else if (rise) begin
        if (long_mode) begin
          active <= 1'b1;
          cnt    <= '0;
        end else begin
          pend <= 1'b1;
        end
      end
    end
  end

  a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r12_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));
  a_r10_pdn_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(pdn));
endmodule

// File: rtl/pcm_hwy_port.sv
module pcm_hwy_port
  import pcm_hwy_pkg::*;
#(
  parameter int unsigned NCH    = NUM_CH,
  parameter int unsigned SLOT_W = SLOT_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_long,
  input  logic [NCH-1:0]        fsx,
  input  logic [NCH-1:0]        fsr,
  input  logic [NCH-1:0]        pdn,
  input  logic [NCH*SLOT_W-1:0] tx_data,
  input  logic                  dr,
  output logic                  dx,
  output logic                  dx_oe,
  output logic                  tsc_n,
  output logic                  tx_collision,
  output logic [NCH*SLOT_W-1:0] rx_data,
  output logic [NCH-1:0]        rx_valid
);
  logic long_mode;
  logic dr_q;

  assign long_mode = (frame_fmt_e'(frame_long) == FRAME_LONG);

  // Receive data is sampled on the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dr_q <= 1'b0;
    else        dr_q <= dr;
  end

  pcm_hwy_tx #(.NCH(NCH), .SLOT_W(SLOT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_mode (long_mode),
    .fsx       (fsx),
    .pdn       (pdn),
    .tx_data   (tx_data),
    .dx        (dx),
    .dx_oe     (dx_oe),
    .tsc_n     (tsc_n),
    .collision (tx_collision)
  );

  for (genvar g = 0; g < int'(NCH); g++) begin : g_rx
    pcm_hwy_rx_lane #(.SLOT_W(SLOT_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .long_mode (long_mode),
      .fsr       (fsr[g]),
      .pdn       (pdn[g]),
      .dr_bit    (dr_q),
      .rx_byte   (rx_data[g*SLOT_W +: SLOT_W]),
      .rx_valid  (rx_valid[g])
    );
  end
endmodule

// File: tb/pcm_hwy_port_bench.sv
module pcm_hwy_port_bench;
  localparam int NCH = 4;
  localparam int SW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_long = 1'b1;
  logic [NCH-1:0]  fsx = '0, fsr = '0, pdn = '0;
  logic [NCH*SW-1:0] tx_data = 32'hE1_3C_96_A5;
  logic            dr = 1'b0;
  logic            dx, dx_oe, tsc_n, tx_collision;
  logic [NCH*SW-1:0] rx_data;
  logic [NCH-1:0]  rx_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pcm_hwy_port u_pcm_hwy_port (
    .clk(clk), .rst_n(rst_n), .frame_long(frame_long), .fsx(fsx), .fsr(fsr),
    .pdn(pdn), .tx_data(tx_data), .dr(dr), .dx(dx), .dx_oe(dx_oe),
    .tsc_n(tsc_n), .tx_collision(tx_collision), .rx_data(rx_data),
    .rx_valid(rx_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] txb(input int ch);
    return tx_data[ch*SW +: SW];
  endfunction

  // At the first-bit cycle: check eight bits MSB first on the line
  task automatic expect_slot(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) begin
      if (i != 7) tick();
      check(dx_oe === 1'b1 && dx === b[i] && tsc_n === 1'b0, req,
            {dx_oe, dx, tsc_n}, {1'b1, b[i], 1'b0});
    end
  endtask

  task automatic expect_idle(input string req);
    check(dx_oe === 1'b0 && dx === 1'b0 && tsc_n === 1'b1, req,
          {dx_oe, dx, tsc_n}, 3'b001);
  endtask

  task automatic t_reset();
    expect_idle("R5 reset");
    check(rx_valid === '0 && tx_collision === 1'b0, "R12 reset",
          {rx_valid, tx_collision}, 0);
  endtask

  task automatic t_tx_long(input int ch);
    frame_long = 1'b1;
    fsx[ch] = 1'b1;
    tick();
    fsx[ch] = 1'b0;
    expect_slot(txb(ch), "R1 long tx");
    tick();
    expect_idle("R5/R6 after long slot");
  endtask

  task automatic t_tx_short(input int ch);
    frame_long = 1'b0;
    fsx[ch] = 1'b1;
    tick();
    fsx[ch] = 1'b0;
    check(dx_oe === 1'b0, "R2 short no early drive", dx_oe, 0);
    tick();
    expect_slot(txb(ch), "R2 short tx");
    tick();
    expect_idle("R5 after short slot");
    frame_long = 1'b1;
  endtask

  task automatic t_back_to_back();
    frame_long = 1'b1;
    fsx[0] = 1'b1;
    tick();
    fsx[0] = 1'b0;
    expect_slot(txb(0), "R7 first slot");
    fsx[3] = 1'b1;
    tick();
    fsx[3] = 1'b0;
    expect_slot(txb(3), "R7 second slot seamless");
    tick();
    expect_idle("R7 release after second");
  endtask

  task automatic t_collision();
    frame_long = 1'b1;
    fsx = 4'b0110;
    tick();
    fsx = '0;
    check(tx_collision === 1'b1, "R8 collision pulse", tx_collision, 1);
    expect_slot(txb(1), "R8 lowest wins");
    check(tx_collision === 1'b0, "R8 pulse one cycle", tx_collision, 0);
    tick();
    expect_idle("R8 release");
  endtask

  task automatic t_pdn_tx();
    pdn[2] = 1'b1;
    fsx[2] = 1'b1;
    tick();
    fsx[2] = 1'b0;
    for (int i = 0; i < 10; i++) begin
      check(dx_oe === 1'b0, "R9 pdn sync ignored", dx_oe, 0);
      tick();
    end
    pdn[2] = 1'b0;
    fsx[0] = 1'b1;
    tick();
    fsx[0] = 1'b0;
    check(dx_oe === 1'b1, "R9 slot started", dx_oe, 1);
    tick();
    tick();
    pdn[0] = 1'b1;
    tick();
    check(dx_oe === 1'b0 && tsc_n === 1'b1, "R9 abort mid slot", {dx_oe, tsc_n}, 2'b01);
    pdn[0] = 1'b0;
    tick();
  endtask

  task automatic t_held_sync();
    frame_long = 1'b1;
    fsx[2] = 1'b1;
    tick();
    expect_slot(txb(2), "R11 held sync slot");
    for (int i = 0; i < 4; i++) begin
      tick();
      check(dx_oe === 1'b0, "R11 single slot", dx_oe, 0);
    end
    fsx[2] = 1'b0;
    tick();
  endtask

  task automatic t_rx(input int ch, input logic [7:0] b, input bit lng,
                      input bit off, input string req);
    frame_long = lng;
    pdn[ch] = off;
    fsr[ch] = 1'b1;
    if (lng) dr = b[7];
    tick();
    fsr[ch] = 1'b0;
    if (!lng) begin
      tick();
      dr = b[7];
    end
    for (int i = 6; i >= 0; i--) begin
      tick();
      dr = b[i];
    end
    tick();
    if (off) begin
      check(rx_valid === '0, req, rx_valid, 0);
    end else begin
      check(rx_valid === 4'(1 << ch) && rx_data[ch*SW +: SW] === b, req,
            {rx_valid, rx_data[ch*SW +: SW]}, {4'(1 << ch), b});
    end
    tick();
    check(rx_valid === '0, "R12 strobe one cycle", rx_valid, 0);
    if (!off)
      check(rx_data[ch*SW +: SW] === b, "R12 byte held", rx_data[ch*SW +: SW], b);
    dr = 1'b0;
    pdn[ch] = 1'b0;
    frame_long = 1'b1;
    tick();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_tx_long(0);
    t_tx_long(2);
    t_tx_short(1);
    t_back_to_back();
    t_collision();
    t_pdn_tx();
    t_held_sync();
    t_rx(1, 8'hC3, 1'b1, 1'b0, "R3 long rx");
    t_rx(3, 8'h5A, 1'b0, 1'b0, "R4 short rx");
    t_rx(0, 8'h81, 1'b1, 1'b0, "R3 long rx ch0");
    t_rx(2, 8'h77, 1'b1, 1'b1, "R10 pdn rx silent");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule